// File: doc/BRIEF.md
# Command Port Register Routing Decoder

This block sits behind the command-write port of a content-addressable memory controller and interprets the 16-bit words written there. It holds the routing state of the port. A persistent source choice steers every data read. A persistent destination choice, with its mask select and validity setting, steers every data write. A one-shot override names the register that the very next command read or command write touches. Once that one access has happened, command reads return the status register again and command writes go back to the instruction decoder.

The block also owns the memory address register. Any routing instruction may carry an address flag, and then the following command write is taken as an absolute address rather than as an instruction. Each data cycle that reaches the memory array steps the address register up or down, following a direction input from the control register. A command write under override to a register that cannot be written is dropped. The memory array, the compare logic and the data mover are outside the block. They consume the select outputs.

Top module: `cmd_route_decoder`

## Requirements
- R1: After reset the persistent source and destination are the comparand (code 0), the mask select and validity are 0, no override is active, no address cycle is pending, the address register is 0 and command reads return status.
- R2: An instruction word with bits 15:12 = 0, bits 10:8 = 000, bits 7:3 = 0 and bits 2:0 = s with s in 0..3 (0 comparand, 1 mask one, 2 mask two, 3 memory) sets the persistent source to s; s in 4..7 makes the whole word ignored.
- R3: A word with bits 15:12 = 0 and bits 10:8 = 001 sets the persistent destination to bits 5:3 when that value is in 0..3 (same codes as R2), together with the mask select from bits 7:6 and the validity setting from bits 2:0; destination values 4..7 make the whole word ignored.
- R4: When bit 11 of an accepted R2 or R3 word is 1, an address cycle becomes pending: the next command write loads its low address bits into the address register, is not decoded as an instruction and ends the pending state.
- R5: The word 0x0200 with bits 5:3 = r (all other bits zero) arms a one-shot override of register r (0 comparand, 1 mask one, 2 mask two, 3 control, 4 address, 5 next-free, 6 persistent-source, 7 persistent-destination); while armed, command reads select r, and the first command read or command write clears it.
- R6: A command write under override raises the register write strobe with the override code only for codes 0..4; codes 5, 6 and 7 are read-only and get no strobe; a write under override of code 4 loads the address register.
- R7: A command read under override of code 6 presents the device ID parameter on the 12-bit ID field (bits 15:4 of the read word); at all other times that field is 0.
- R8: A data read while the source is memory, or a data write while the destination is memory, steps the address register by one after the access: up when the direction input is 0, down when it is 1; an address load in the same cycle takes priority.
- R9: With the default wrapping option, stepping up from the highest address gives 0 and stepping down from 0 gives the highest address.
- R10: An instruction word that matches none of the R2, R3 or R5 forms (for example a data-move word with bits 10:8 = 011) leaves all routing state and the address register unchanged.
- R11: Command reads return the status register (status flag 1, select 0) whenever no override is armed, and never while one is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Command write cycle strobe |
| cmd_wdata | input | 16 | Command write word |
| cmd_rd | input | 1 | Command read cycle strobe |
| data_rd | input | 1 | Data read cycle strobe |
| data_wr | input | 1 | Data write cycle strobe |
| step_down | input | 1 | Control-register direction bit: 1 steps the address down |
| cmd_rd_status | output | 1 | Command read returns the status register |
| cmd_rd_sel | output | 3 | Register code for an overridden command read, else 0 |
| cmd_rd_id | output | 12 | Device ID field for an overridden read of code 6, else 0 |
| cmd_reg_wr | output | 1 | Write strobe to the overridden register |
| cmd_reg_sel | output | 3 | Register code for the override write |
| instr_take | output | 1 | The current command write is decoded as an instruction |
| data_rd_sel | output | 3 | Persistent source code |
| data_wr_sel | output | 3 | Persistent destination code |
| wr_mask_sel | output | 2 | Mask select for data writes |
| wr_valid | output | 3 | Validity setting for memory writes |
| addr | output | 12 | Address register |
| addr_pend | output | 1 | Next command write is an address |
| ovr_active | output | 1 | One-shot override armed |

## Verification
The bench goes after the wrap edges of the address register. A design that saturated there, or stepped the wrong way, would show the wrong address in the cycle after the access. It writes to the read-only codes under override, where a missing guard would raise a write strobe. It checks that the override clears after exactly one access, because a design that kept it armed would keep hiding the status register from command reads. It sends address cycles whose words look like valid instructions, and a design that decoded those words would change the routing state instead of loading the address.

// File: rtl/cmd_route_pkg.sv
package cmd_route_pkg;

   // persistent source / destination codes
   localparam logic [2:0] PC_CMP = 3'd0;
   localparam logic [2:0] PC_MK1 = 3'd1;
   localparam logic [2:0] PC_MK2 = 3'd2;
   localparam logic [2:0] PC_MEM = 3'd3;

   // override register codes
   localparam logic [2:0] RG_CMP = 3'd0;
   localparam logic [2:0] RG_MK1 = 3'd1;
   localparam logic [2:0] RG_MK2 = 3'd2;
   localparam logic [2:0] RG_CTL = 3'd3;
   localparam logic [2:0] RG_ADR = 3'd4;
   localparam logic [2:0] RG_NXF = 3'd5;
   localparam logic [2:0] RG_PSR = 3'd6;
   localparam logic [2:0] RG_PDR = 3'd7;

   typedef struct packed {
      logic       is_src;
      logic       is_dst;
      logic       is_ovr;
      logic       aflag;
      logic [2:0] sel;
      logic [1:0] mask;
      logic [2:0] valid;
   } dec_t;

   function automatic logic reg_writable(input logic [2:0] code);
      return (code <= RG_ADR);
   endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
   import cmd_route_pkg::*;
#(
   parameter int CMD_W = 16
) (
   input  logic [CMD_W-1:0] word,
   output dec_t             dec
);
   localparam int FLAG_BIT = 11;

   logic top_zero;
   logic grp_src;
   logic grp_dst;
   logic grp_ovr;

   always_comb begin
      top_zero = (word[15:12] == 4'b0000);
      grp_src  = top_zero && (word[10:8] == 3'b000) && (word[7:3] == 5'b0)
                 && (word[2:0] <= PC_MEM);
      grp_dst  = top_zero && (word[10:8] == 3'b001) && (word[5:3] <= PC_MEM);
      grp_ovr  = (word[15:8] == 8'h02) && (word[7:6] == 2'b00) && (word[2:0] == 3'b000);

      dec        = '0;
      dec.is_src = grp_src;
      dec.is_dst = grp_dst;
      dec.is_ovr = grp_ovr;
      dec.aflag  = word[FLAG_BIT] && (grp_src || grp_dst);
      dec.mask   = word[7:6];
      dec.valid  = word[2:0];
      dec.sel    = grp_src ? word[2:0] : word[5:3];
   end

   always_comb begin
      assert (!(dec.is_src && dec.is_dst) && !(dec.is_src && dec.is_ovr) && !(dec.is_dst && dec.is_ovr))
         else $error("p_excl_forms_r10: decoded forms overlap");
   end
endmodule

// File: rtl/route_state.sv
module route_state
   import cmd_route_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_wr,
   input  logic       cmd_rd,
   input  dec_t       dec,
   output logic       take,
   output logic       addr_cyc,
   output logic [2:0] src_q,
   output logic [2:0] dst_q,
   output logic [1:0] mask_q,
   output logic [2:0] valid_q,
   output logic       ovr_q,
   output logic [2:0] ovr_reg_q,
   output logic       pend_q
);
   logic ovr_used;

   always_comb begin
      take     = cmd_wr && !pend_q && !ovr_q;
      addr_cyc = cmd_wr && pend_q;
      ovr_used = ovr_q && (cmd_rd || (cmd_wr && !pend_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q     <= PC_CMP;
         dst_q     <= PC_CMP;
         mask_q    <= 2'd0;
         valid_q   <= 3'd0;
         ovr_q     <= 1'b0;
         ovr_reg_q <= RG_CMP;
         pend_q    <= 1'b0;
      end else begin
         if (addr_cyc)
            pend_q <= 1'b0;
         if (ovr_used)
            ovr_q <= 1'b0;
         if (take) begin
            if (dec.is_src) begin
               src_q  <= dec.sel;
               pend_q <= dec.aflag;
            end
            if (dec.is_dst) begin
               dst_q   <= dec.sel;
               mask_q  <= dec.mask;
               valid_q <= dec.valid;
               pend_q  <= dec.aflag;
            end
            if (dec.is_ovr) begin
               ovr_q     <= 1'b1;
               ovr_reg_q <= dec.sel;
            end
         end
      end
   end

   p_pend_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_cyc |=> !pend_q);

   p_ovr_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_used |=> !ovr_q);

   p_ignore_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !dec.is_src && !dec.is_dst && !dec.is_ovr)
      |=> ($stable(src_q) && $stable(dst_q) && $stable(mask_q) && $stable(valid_q) && !pend_q));

   p_no_pend_and_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_q && ovr_q));
endmodule

// File: rtl/addr_reg.sv
module addr_reg #(
   parameter int AW   = 12,
   parameter bit WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [AW-1:0] ld_val,
   input  logic          step,
   input  logic          down,
   output logic [AW-1:0] addr_q
);
   localparam logic [AW-1:0] TOP = {AW{1'b1}};
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] stepped;

   generate
      if (WRAP) begin : g_wrap
         always_comb stepped = down ? (addr_q - ONE) : (addr_q + ONE);

         p_wrap_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !ld && down && addr_q == '0) |=> (addr_q == TOP));
         p_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !ld && !down && addr_q == TOP) |=> (addr_q == '0));
      end else begin : g_sat
         always_comb begin
            if (down)
               stepped = (addr_q == '0) ? addr_q : (addr_q - ONE);
            else
               stepped = (addr_q == TOP) ? addr_q : (addr_q + ONE);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (ld)
         addr_q <= ld_val;
      else if (step)
         addr_q <= stepped;
   end

   p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (addr_q == $past(ld_val)));

   p_step_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld && !down && addr_q != TOP) |=> (addr_q == $past(addr_q) + ONE));

   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ld) |=> $stable(addr_q));
endmodule

// File: rtl/cmd_route_decoder.sv
module cmd_route_decoder
   import cmd_route_pkg::*;
#(
   parameter int          CMD_W   = 16,
   parameter int          AW      = 12,
   parameter bit          AR_WRAP = 1'b1,
   parameter bit          ID_EN   = 1'b1,
   parameter logic [11:0] DEV_ID  = 12'hA5C
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             cmd_rd,
   input  logic             data_rd,
   input  logic             data_wr,
   input  logic             step_down,
   output logic             cmd_rd_status,
   output logic [2:0]       cmd_rd_sel,
   output logic [11:0]      cmd_rd_id,
   output logic             cmd_reg_wr,
   output logic [2:0]       cmd_reg_sel,
   output logic             instr_take,
   output logic [2:0]       data_rd_sel,
   output logic [2:0]       data_wr_sel,
   output logic [1:0]       wr_mask_sel,
   output logic [2:0]       wr_valid,
   output logic [AW-1:0]    addr,
   output logic             addr_pend,
   output logic             ovr_active
);
   localparam int ID_W = 12;

   generate
      if (CMD_W != 16) begin : g_bad_cmd_w
         $error("cmd_route_decoder: CMD_W must be 16");
      end
      if (AW < 1 || AW > CMD_W) begin : g_bad_aw
         $error("cmd_route_decoder: AW must be 1..CMD_W");
      end
   endgenerate

   dec_t       dec;
   logic       take;
   logic       addr_cyc;
   logic [2:0] ovr_reg;
   logic       ovr_q;
   logic       pend_q;
   logic       ar_ld;
   logic       ar_step;

   cmd_decode #(.CMD_W(CMD_W)) u_dec (
      .word (cmd_wdata),
      .dec  (dec)
   );

   route_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .cmd_rd    (cmd_rd),
      .dec       (dec),
      .take      (take),
      .addr_cyc  (addr_cyc),
      .src_q     (data_rd_sel),
      .dst_q     (data_wr_sel),
      .mask_q    (wr_mask_sel),
      .valid_q   (wr_valid),
      .ovr_q     (ovr_q),
      .ovr_reg_q (ovr_reg),
      .pend_q    (pend_q)
   );

   always_comb begin
      instr_take    = take;
      addr_pend     = pend_q;
      ovr_active    = ovr_q;
      cmd_rd_status = !ovr_q;
      cmd_rd_sel    = ovr_q ? ovr_reg : 3'd0;
      cmd_reg_sel   = ovr_reg;
      cmd_reg_wr    = cmd_wr && ovr_q && !pend_q && reg_writable(ovr_reg);
      ar_ld         = addr_cyc || (cmd_reg_wr && ovr_reg == RG_ADR);
      ar_step       = (data_rd && data_rd_sel == PC_MEM) || (data_wr && data_wr_sel == PC_MEM);
   end

   generate
      if (ID_EN) begin : g_id
         always_comb cmd_rd_id = (ovr_q && ovr_reg == RG_PSR) ? DEV_ID : '0;
      end else begin : g_no_id
         always_comb cmd_rd_id = '0;
      end
   endgenerate

   addr_reg #(.AW(AW), .WRAP(AR_WRAP)) u_ar (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (ar_ld),
      .ld_val (cmd_wdata[AW-1:0]),
      .step   (ar_step),
      .down   (step_down),
      .addr_q (addr)
   );

   always_comb begin
      assert (!(cmd_reg_wr && cmd_reg_sel > RG_ADR))
         else $error("p_ro_guard_r6: write strobe on read-only register");
      assert (!(cmd_rd_status && cmd_rd_id != '0))
         else $error("p_id_only_ovr_r7: ID field set on status read");
   end

   p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rd && ovr_q && !$isunknown(ID_W)) |=> cmd_rd_status);

   p_take_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_take && cmd_reg_wr));
endmodule

// File: tb/cmd_route_decoder_bench.sv
module cmd_route_decoder_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 12;
   localparam logic [11:0] DEV_ID     = 12'hA5C;
   localparam int          N_RAND     = 3000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_wr = 1'b0;
   logic [15:0]   cmd_wdata = '0;
   logic          cmd_rd = 1'b0;
   logic          data_rd = 1'b0;
   logic          data_wr = 1'b0;
   logic          step_down = 1'b0;
   logic          cmd_rd_status;
   logic [2:0]    cmd_rd_sel;
   logic [11:0]   cmd_rd_id;
   logic          cmd_reg_wr;
   logic [2:0]    cmd_reg_sel;
   logic          instr_take;
   logic [2:0]    data_rd_sel;
   logic [2:0]    data_wr_sel;
   logic [1:0]    wr_mask_sel;
   logic [2:0]    wr_valid;
   logic [AW-1:0] addr;
   logic          addr_pend;
   logic          ovr_active;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // reference model state
   logic [2:0]    m_src, m_dst, m_val, m_oreg;
   logic [1:0]    m_mask;
   logic          m_ovr, m_pend;
   logic [AW-1:0] m_ar;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_route_decoder #(.AW(AW), .DEV_ID(DEV_ID)) u_cmd_route_decoder (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .cmd_rd(cmd_rd), .data_rd(data_rd), .data_wr(data_wr), .step_down(step_down),
      .cmd_rd_status(cmd_rd_status), .cmd_rd_sel(cmd_rd_sel), .cmd_rd_id(cmd_rd_id),
      .cmd_reg_wr(cmd_reg_wr), .cmd_reg_sel(cmd_reg_sel), .instr_take(instr_take),
      .data_rd_sel(data_rd_sel), .data_wr_sel(data_wr_sel), .wr_mask_sel(wr_mask_sel),
      .wr_valid(wr_valid), .addr(addr), .addr_pend(addr_pend), .ovr_active(ovr_active)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic bit f_src(input logic [15:0] w);
      return w[15:12] == 0 && w[10:8] == 0 && w[7:3] == 0 && w[2:0] < 4;
   endfunction
   function automatic bit f_dst(input logic [15:0] w);
      return w[15:12] == 0 && w[10:8] == 3'b001 && w[5:3] < 4;
   endfunction
   function automatic bit f_ovr(input logic [15:0] w);
      return (w & 16'hFFC7) == 16'h0200;
   endfunction
   function automatic logic [AW-1:0] f_step(input logic [AW-1:0] a, input logic dn);
      return dn ? a - 1'b1 : a + 1'b1;
   endfunction

   task automatic check_state();
      chk("R2", "data_rd_sel", data_rd_sel, m_src);
      chk("R3", "data_wr_sel", data_wr_sel, m_dst);
      chk("R3", "wr_mask_sel", wr_mask_sel, m_mask);
      chk("R3", "wr_valid", wr_valid, m_val);
      chk("R4", "addr_pend", addr_pend, m_pend);
      chk("R8", "addr", addr, m_ar);
      chk("R5", "ovr_active", ovr_active, m_ovr);
      chk("R5", "cmd_rd_sel", cmd_rd_sel, m_ovr ? m_oreg : 0);
      chk("R11", "cmd_rd_status", cmd_rd_status, !m_ovr);
      chk("R7", "cmd_rd_id", cmd_rd_id, (m_ovr && m_oreg == 6) ? DEV_ID : 0);
   endtask

   // one clock: drive at negedge, check combinational, update model, check state
   task automatic cyc(input bit cw, input logic [15:0] wd, input bit cr,
                      input bit dr, input bit dw, input bit dn);
      bit take, rwr, ld, stp;
      logic [AW-1:0] nar;
      cmd_wr = cw; cmd_wdata = wd; cmd_rd = cr; data_rd = dr; data_wr = dw; step_down = dn;
      #1;
      take = cw && !m_pend && !m_ovr;
      rwr  = cw && m_ovr && !m_pend && m_oreg <= 4;
      ld   = (m_pend && cw) || (rwr && m_oreg == 4);
      stp  = (dr && m_src == 3) || (dw && m_dst == 3);
      chk("R6", "cmd_reg_wr", cmd_reg_wr, rwr);
      chk("R4", "instr_take", instr_take, take);
      @(posedge clk);
      nar = ld ? wd[AW-1:0] : (stp ? f_step(m_ar, dn) : m_ar);
      if (m_pend && cw) m_pend = 1'b0;
      if (m_ovr && (cr || (cw && !m_pend))) m_ovr = 1'b0;
      if (take) begin
         if (f_src(wd)) begin m_src = wd[2:0]; m_pend = wd[11]; end
         if (f_dst(wd)) begin
            m_dst = wd[5:3]; m_mask = wd[7:6]; m_val = wd[2:0]; m_pend = wd[11];
         end
         if (f_ovr(wd)) begin m_ovr = 1'b1; m_oreg = wd[5:3]; end
      end
      m_ar = nar;
      @(negedge clk);
      check_state();
   endtask

   function automatic logic [15:0] rand_word();
      int k = int'($urandom_range(0, 5));
      logic [15:0] r = 16'($urandom);
      case (k)
         0: return {4'h0, r[11], 3'b000, 5'b0, r[2:0]};
         1: return {4'h0, r[11], 3'b001, r[7:0]};
         2: return {8'h02, 2'b00, r[5:3], 3'b000};
         3: return {4'h0, r[11], 3'b011, r[7:0]};
         default: return r;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0017));
      m_src = 0; m_dst = 0; m_val = 0; m_oreg = 0; m_mask = 0;
      m_ovr = 0; m_pend = 0; m_ar = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "reset src", data_rd_sel, 0);
      chk("R1", "reset dst", data_wr_sel, 0);
      chk("R1", "reset addr", addr, 0);
      chk("R1", "reset status", cmd_rd_status, 1);
      chk("R1", "reset pend", addr_pend, 0);
      chk("R1", "reset valid/mask", {wr_valid, wr_mask_sel}, 0);

      // R2 + R8: source memory at current address, step up
      cyc(1, 16'h0003, 0, 0, 0, 0);
      cyc(0, 16'h0000, 0, 1, 0, 0);
      chk("R8", "step up from 0", addr, 1);
      // R3 + R4: destination memory, absolute address 0xFFF
      cyc(1, 16'h099D, 0, 0, 0, 0);
      chk("R4", "pending after flagged word", addr_pend, 1);
      cyc(1, 16'h0FFF, 0, 0, 0, 0);
      chk("R4", "address loaded", addr, 12'hFFF);
      chk("R4", "address word not decoded", data_rd_sel, 3);
      // R9: wrap both ways
      cyc(0, 16'h0000, 0, 0, 1, 0);
      chk("R9", "wrap up to 0", addr, 0);
      cyc(0, 16'h0000, 0, 0, 1, 1);
      chk("R9", "wrap down to max", addr, 12'hFFF);
      // R7 + R6: override of read-only PS, then write dropped
      cyc(1, 16'h0230, 0, 0, 0, 0);
      chk("R7", "device id", cmd_rd_id, DEV_ID);
      chk("R11", "no status under override", cmd_rd_status, 0);
      cyc(1, 16'h1234, 0, 0, 0, 0);
      chk("R5", "override cleared", ovr_active, 0);
      // R6: override write to address register
      cyc(1, 16'h0220, 0, 0, 0, 0);
      cyc(1, 16'h0123, 0, 0, 0, 0);
      chk("R6", "AR written", addr, 12'h123);
      // R10: data-move and reserved-source words ignored
      cyc(1, 16'h0B5A, 0, 0, 0, 0);
      cyc(1, 16'h0006, 0, 0, 0, 0);
      chk("R10", "src unchanged", data_rd_sel, 3);
      chk("R10", "dst unchanged", data_wr_sel, 3);
      chk("R10", "addr unchanged", addr, 12'h123);
      chk("R10", "no pending", addr_pend, 0);
      // R5: override consumed by a command read
      cyc(1, 16'h0208, 0, 0, 0, 0);
      cyc(0, 16'h0000, 1, 0, 0, 0);
      chk("R5", "cleared by read", ovr_active, 0);

      for (int i = 0; i < N_RAND; i++) begin
         bit cw = ($urandom_range(0, 1) == 1);
         cyc(cw, m_pend ? 16'($urandom) : rand_word(),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
             ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule